// File: doc/BRIEF.md
# Snooped Address Parity Checker

This block protects a 32-bit processor address bus with odd parity, one bit per byte lane. When the local agent owns the bus and drives an address, the block produces the four parity bits. It registers them in the same stage and under the same enable as the address, so parity and address appear, change and float together.

When another agent owns the bus, the block checks the parity on the addresses it snoops. An ordinary transfer start is checked on its single beat. A direct-store tenure takes two beats: the first comes with the extended transfer-start strobe, and the second follows on the next cycle. The block checks only the first beat, and only when the tenure is a reply whose receiver tag equals the local processor ID. The second beat is never checked.

A detected error sets sticky per-lane flags and gives a one-cycle error pulse. The error then escalates either to a machine-check request or to a sticky checkstop request, depending on two control bits.

Top module: `snoop_addr_parity`

## Requirements
- R1: Parity bit `i` is odd parity over `addr[8*i+7:8*i]`, so big-endian address bit 0 is `addr[31]` and is covered by `parOut[3]`. For every lane, the count of ones in the byte plus its parity bit is odd.
- R2: One cycle after `outDrive` is sampled high, `busOe` is 1, `addrOut` equals the sampled `outAddr`, and `parOut` holds its R1 parity. One cycle after `outDrive` is sampled low, `busOe`, `addrOut` and `parOut` are all 0.
- R3: While `localMaster` is 1, no snooped beat is checked: `errPulse`, `mcReq` and the flags do not change because of that beat.
- R4: A beat with `snpValid`=1 and `snpDsStart`=0, outside a direct-store second beat, is checked. If any lane fails, `errPulse` is 1 in the following cycle.
- R5: A direct-store first beat (`snpDsStart`=1) is checked only when `snpDsReply`=1 and the receiver tag `snpAddr[3:0]` equals `procId`.
- R6: The cycle after a direct-store first beat is its second beat. That beat never raises an error, even if `snpValid` or `snpDsStart` is asserted and its parity is even.
- R7: A direct-store first beat with a mismatched tag, or with `snpDsReply`=0, never raises an error.
- R8: `errLanes` keeps the OR of all failing lanes seen in checked beats. A pulse on `clrErr` empties it. When a clear and a new error fall in the same cycle, the flags end up equal to the new error's lanes only.
- R9: On an error, `cfgParChk`=1 requests a checkstop. With `cfgParChk`=0, `cfgMcEn`=1 gives a one-cycle `mcReq` instead, and `cfgMcEn`=0 requests a checkstop. The control bits are sampled in the same cycle as the beat. Snooped and direct-store errors follow the same rules.
- R10: `chkstopReq` stays at 1 until reset. Reset brings every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| localMaster | input | 1 | Local agent owns the address bus |
| outAddr | input | 32 | Address the local agent is about to drive |
| outDrive | input | 1 | Drive request for the address and parity |
| addrOut | output | 32 | Registered address towards the bus |
| parOut | output | 4 | Registered parity, one bit per byte lane |
| busOe | output | 1 | Common output enable for address and parity |
| snpAddr | input | 32 | Snooped address |
| snpPar | input | 4 | Snooped parity |
| snpValid | input | 1 | Ordinary transfer start on the snooped bus |
| snpDsStart | input | 1 | First beat of a direct-store tenure |
| snpDsReply | input | 1 | The direct-store tenure is a reply |
| procId | input | 4 | Static local processor ID |
| cfgParChk | input | 1 | Parity errors always request a checkstop |
| cfgMcEn | input | 1 | Machine-check enable |
| clrErr | input | 1 | Clears the sticky lane flags |
| errLanes | output | 4 | Sticky failing-lane flags |
| errPulse | output | 1 | One-cycle error indication |
| mcReq | output | 1 | One-cycle machine-check request |
| chkstopReq | output | 1 | Sticky checkstop request |

## Verification
A flag clear and a fresh parity error can land in the same cycle. The clear must not wipe out the new lanes, and the old lanes must not survive it. The bench provokes this directly: it first sets flags on one lane, then pulses `clrErr` while a checked beat fails on a different lane. It also lets random clears fall on random failing beats. In each case the flags one cycle later are compared with a bench model that first empties the flags and then ORs in the new failing lanes.

// File: rtl/snp_par_pkg.sv
package snp_par_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic checkEn;  // the current snooped beat is qualified for a parity check
    logic flagClr;  // empty the sticky lane flags
  } ctlStrobe_t;

endpackage

// File: rtl/snp_par_datapath.sv
module snp_par_datapath
  import snp_par_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LANE_W  = 8,
  parameter int TAG_W   = 4,
  parameter int TAG_LSB = 0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             outAddr,
  input  logic                          outDrive,
  output logic [ADDR_W-1:0]             addrOut,
  output logic [ADDR_W/LANE_W-1:0]      parOut,
  output logic                          busOe,
  input  logic [ADDR_W-1:0]             snpAddr,
  input  logic [ADDR_W/LANE_W-1:0]      snpPar,
  input  logic [TAG_W-1:0]              procId,
  input  ctlStrobe_t                    strobe,
  output logic [ADDR_W/LANE_W-1:0]      laneBad,
  output logic                          tagHit,
  output logic [ADDR_W/LANE_W-1:0]      errLanes
);
  localparam int LANES = ADDR_W / LANE_W;

  logic [LANES-1:0] genPar;

  // Per-lane parity generation for the outgoing address and check of the snooped one.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign genPar[i]  = ~(^outAddr[i*LANE_W +: LANE_W]);
    assign laneBad[i] = ~(^{snpAddr[i*LANE_W +: LANE_W], snpPar[i]});

    // Every driven lane carries an odd number of ones.
    AST_DRIVE_ODD: assert property (@(posedge clk) disable iff (!rstN)
      busOe |-> (^{addrOut[i*LANE_W +: LANE_W], parOut[i]}) == 1'b1); // R1
  end

  assign tagHit = (snpAddr[TAG_LSB +: TAG_W] == procId);

  // Address, parity and enable share one register stage.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrOut <= '0;
      parOut  <= '0;
      busOe   <= 1'b0;
    end else begin
      busOe   <= outDrive;
      addrOut <= outDrive ? outAddr : '0;
      parOut  <= outDrive ? genPar  : '0;
    end
  end

  // Sticky lane flags: a clear is applied first, then the new failing lanes are ORed in.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errLanes <= '0;
    end else begin
      errLanes <= (strobe.flagClr ? '0 : errLanes) | (strobe.checkEn ? laneBad : '0);
    end
  end

  AST_FLAGS_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.flagClr |=> ((errLanes & $past(errLanes)) == $past(errLanes))); // R8

  AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.flagClr && !strobe.checkEn) |=> $stable(errLanes)); // R8

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !busOe |-> (addrOut == '0 && parOut == '0)); // R2

endmodule

// File: rtl/snp_par_control.sv
module snp_par_control
  import snp_par_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             localMaster,
  input  logic             snpValid,
  input  logic             snpDsStart,
  input  logic             snpDsReply,
  input  logic             tagHit,
  input  logic [LANES-1:0] laneBad,
  input  logic             cfgParChk,
  input  logic             cfgMcEn,
  input  logic             clrErr,
  output ctlStrobe_t       strobe,
  output logic             errPulse,
  output logic             mcReq,
  output logic             chkstopReq
);
  typedef enum logic {BEAT_IDLE, BEAT_SECOND} beatState_t;

  beatState_t beatState;
  logic       secondBeat;
  logic       normalHit;
  logic       dsHit;
  logic       errNow;

  assign secondBeat = (beatState == BEAT_SECOND);

  // Qualify the current beat.
  assign normalHit = snpValid && !snpDsStart;
  assign dsHit     = snpDsStart && snpDsReply && tagHit;

  always_comb begin
    strobe         = '0;
    strobe.checkEn = !localMaster && !secondBeat && (normalHit || dsHit);
    strobe.flagClr = clrErr;
  end

  assign errNow = strobe.checkEn && (|laneBad);

  // Tenure tracking: a first beat always opens a second beat on the next cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatState <= BEAT_IDLE;
    end else if (snpDsStart && !secondBeat) begin
      beatState <= BEAT_SECOND;
    end else begin
      beatState <= BEAT_IDLE;
    end
  end

  // Escalation.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errPulse   <= 1'b0;
      mcReq      <= 1'b0;
      chkstopReq <= 1'b0;
    end else begin
      errPulse <= errNow;
      mcReq    <= errNow && !cfgParChk && cfgMcEn;
      if (errNow && (cfgParChk || !cfgMcEn)) begin
        chkstopReq <= 1'b1;
      end
    end
  end

  AST_MASTER_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    localMaster |=> !errPulse); // R3

  AST_SECOND_BEAT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    secondBeat |=> !errPulse); // R6

  AST_TAG_MISS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (snpDsStart && (!tagHit || !snpDsReply)) |=> !errPulse); // R7

  AST_MC_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rstN)
    mcReq |-> errPulse); // R9

  AST_PARCHK_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (errNow && cfgParChk) |=> (chkstopReq && !mcReq)); // R9

  AST_CHKSTOP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    chkstopReq |=> chkstopReq); // R10

endmodule

// File: rtl/snoop_addr_parity.sv
module snoop_addr_parity
  import snp_par_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LANE_W  = 8,
  parameter int TAG_W   = 4,
  parameter int TAG_LSB = 0,
  localparam int LANES  = ADDR_W / LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              localMaster,
  input  logic [ADDR_W-1:0] outAddr,
  input  logic              outDrive,
  output logic [ADDR_W-1:0] addrOut,
  output logic [LANES-1:0]  parOut,
  output logic              busOe,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [LANES-1:0]  snpPar,
  input  logic              snpValid,
  input  logic              snpDsStart,
  input  logic              snpDsReply,
  input  logic [TAG_W-1:0]  procId,
  input  logic              cfgParChk,
  input  logic              cfgMcEn,
  input  logic              clrErr,
  output logic [LANES-1:0]  errLanes,
  output logic              errPulse,
  output logic              mcReq,
  output logic              chkstopReq
);
  ctlStrobe_t       strobe;
  logic [LANES-1:0] laneBad;
  logic             tagHit;

  snp_par_datapath #(
    .ADDR_W (ADDR_W),
    .LANE_W (LANE_W),
    .TAG_W  (TAG_W),
    .TAG_LSB(TAG_LSB)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .outAddr (outAddr),
    .outDrive(outDrive),
    .addrOut (addrOut),
    .parOut  (parOut),
    .busOe   (busOe),
    .snpAddr (snpAddr),
    .snpPar  (snpPar),
    .procId  (procId),
    .strobe  (strobe),
    .laneBad (laneBad),
    .tagHit  (tagHit),
    .errLanes(errLanes)
  );

  snp_par_control #(
    .LANES(LANES)
  ) i_control (
    .clk        (clk),
    .rstN       (rstN),
    .localMaster(localMaster),
    .snpValid   (snpValid),
    .snpDsStart (snpDsStart),
    .snpDsReply (snpDsReply),
    .tagHit     (tagHit),
    .laneBad    (laneBad),
    .cfgParChk  (cfgParChk),
    .cfgMcEn    (cfgMcEn),
    .clrErr     (clrErr),
    .strobe     (strobe),
    .errPulse   (errPulse),
    .mcReq      (mcReq),
    .chkstopReq (chkstopReq)
  );

endmodule

// File: tb/test_snoop_addr_parity.sv
`timescale 1ns/100ps
module test_snoop_addr_parity;

  logic        clk = 1'b0;
  logic        rstN;
  logic        localMaster, outDrive, snpValid, snpDsStart, snpDsReply;
  logic        cfgParChk, cfgMcEn, clrErr;
  logic [31:0] outAddr, snpAddr, addrOut;
  logic [3:0]  snpPar, procId, parOut, errLanes;
  logic        busOe, errPulse, mcReq, chkstopReq;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // Bench model state.
  logic [31:0] expAddr;
  logic [3:0]  expPar, expLanes;
  logic        expOe, expErr, expMc, expChk, expBeat2;
  string       errTag;

  always #2.5 clk = ~clk;

  snoop_addr_parity i_snoop_addr_parity (
    .clk(clk), .rstN(rstN), .localMaster(localMaster), .outAddr(outAddr),
    .outDrive(outDrive), .addrOut(addrOut), .parOut(parOut), .busOe(busOe),
    .snpAddr(snpAddr), .snpPar(snpPar), .snpValid(snpValid),
    .snpDsStart(snpDsStart), .snpDsReply(snpDsReply), .procId(procId),
    .cfgParChk(cfgParChk), .cfgMcEn(cfgMcEn), .clrErr(clrErr),
    .errLanes(errLanes), .errPulse(errPulse), .mcReq(mcReq),
    .chkstopReq(chkstopReq)
  );

  function automatic logic [3:0] oddPar(input logic [31:0] a);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = ~(^a[8*i +: 8]);
    return p;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idleInputs();
    localMaster = 0; outDrive = 0; outAddr = '0;
    snpValid = 0; snpDsStart = 0; snpDsReply = 0;
    snpAddr = '0; snpPar = 4'hF; cfgParChk = 0; cfgMcEn = 0; clrErr = 0;
  endtask

  // Predicts one clock from the current inputs, then compares after the edge.
  task automatic step();
    logic [3:0] badL;
    logic       chk;
    badL = ~oddPar(snpAddr) ^ ~snpPar;  // lanes whose byte+parity has even ones
    for (int i = 0; i < 4; i++) badL[i] = ~(^{snpAddr[8*i +: 8], snpPar[i]});
    chk  = !localMaster && !expBeat2 &&
           ((snpValid && !snpDsStart) ||
            (snpDsStart && snpDsReply && snpAddr[3:0] == procId));
    if (localMaster)       errTag = "R3";
    else if (expBeat2)     errTag = "R6";
    else if (snpDsStart)   errTag = chk ? "R5" : "R7";
    else                   errTag = "R4";
    expErr   = chk && (|badL);
    expMc    = expErr && !cfgParChk && cfgMcEn;
    expChk   = expChk | (expErr && (cfgParChk || !cfgMcEn));
    expLanes = (clrErr ? 4'h0 : expLanes) | (chk ? badL : 4'h0);
    expBeat2 = snpDsStart && !expBeat2;
    expOe    = outDrive;
    expAddr  = outDrive ? outAddr : '0;
    expPar   = outDrive ? oddPar(outAddr) : '0;
    @(posedge clk);
    @(negedge clk);
    check(errTag, "errPulse", {31'b0, errPulse}, {31'b0, expErr});
    check("R9", "mcReq", {31'b0, mcReq}, {31'b0, expMc});
    check("R10", "chkstopReq", {31'b0, chkstopReq}, {31'b0, expChk});
    check("R8", "errLanes", {28'b0, errLanes}, {28'b0, expLanes});
    check("R2", "busOe", {31'b0, busOe}, {31'b0, expOe});
    check("R2", "addrOut", addrOut, expAddr);
    check("R1", "parOut", {28'b0, parOut}, {28'b0, expPar});
  endtask

  task automatic doReset();
    rstN = 0;
    idleInputs();
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rstN = 1;
    expLanes = 0; expChk = 0; expBeat2 = 0;
    check("R10", "reset errLanes", {28'b0, errLanes}, 32'h0);
    check("R10", "reset chkstop", {31'b0, chkstopReq}, 32'h0);
    check("R10", "reset outputs", {26'b0, errPulse, mcReq, busOe, 3'b0}, 32'h0);
    check("R10", "reset addrOut", addrOut, 32'h0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    procId = 4'hA;
    doReset();

    // R1/R2: known parity vector, then release.
    outDrive = 1; outAddr = 32'h8000_0001; step();  // expects parOut 4'b0110
    check("R1", "directed parity", {28'b0, parOut}, 32'h6);
    outDrive = 0; step();

    // R4 with machine check enabled: lane 2 bad.
    cfgMcEn = 1; snpValid = 1; snpAddr = 32'h1234_5678;
    snpPar = oddPar(snpAddr) ^ 4'b0100; step();
    check("R9", "mc on normal error", {31'b0, mcReq}, 32'h1);
    snpValid = 0; step();

    // R3: even parity while master.
    localMaster = 1; snpValid = 1; snpPar = ~oddPar(snpAddr); step();
    localMaster = 0; snpValid = 0; step();

    // R5/R6: direct-store reply, tag hit, bad parity on both beats.
    snpDsStart = 1; snpDsReply = 1; snpAddr = 32'hCAFE_000A;
    snpPar = oddPar(snpAddr) ^ 4'b0001; step();
    snpDsStart = 1; snpValid = 1; snpPar = 4'h0; step();  // second beat, ignored
    snpDsStart = 0; snpValid = 0; step();

    // R7: tag miss and non-reply.
    snpDsStart = 1; snpDsReply = 1; snpAddr = 32'hCAFE_0003; snpPar = 4'h0; step();
    snpDsStart = 0; step();
    snpDsStart = 1; snpDsReply = 0; snpAddr = 32'hCAFE_000A; step();
    snpDsStart = 0; step();

    // R8: clear and a new error in the same cycle.
    snpValid = 1; clrErr = 1; snpAddr = 32'h0F0F_0F0F;
    snpPar = oddPar(snpAddr) ^ 4'b1000; step();
    check("R8", "clear with new error", {28'b0, errLanes}, 32'h8);
    snpValid = 0; clrErr = 1; step();
    clrErr = 0;

    // R9/R10: forced checkstop, stays set, then reset.
    cfgParChk = 1; snpValid = 1; snpPar = ~oddPar(snpAddr); step();
    cfgParChk = 0; snpValid = 0; step(); step();
    check("R10", "checkstop held", {31'b0, chkstopReq}, 32'h1);
    doReset();

    // Random traffic.
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] corrupt;
      localMaster = ($urandom % 4) == 0;
      outDrive    = $urandom % 2;
      outAddr     = $urandom;
      snpValid    = $urandom % 2;
      snpDsStart  = ($urandom % 5) == 0;
      snpDsReply  = $urandom % 2;
      snpAddr     = $urandom;
      if ($urandom % 2) snpAddr[3:0] = procId;
      for (int i = 0; i < 4; i++) corrupt[i] = ($urandom % 5) == 0;
      snpPar      = oddPar(snpAddr) ^ corrupt;
      cfgParChk   = ($urandom % 8) == 0;
      cfgMcEn     = ($urandom % 4) != 0;
      clrErr      = ($urandom % 10) == 0;
      step();
      if (n % 1000 == 999) doReset();
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule